// File: doc/BRIEF.md
# Byte-Lane RAM with Selectable Read-During-Write Output

This block is a single-clock synchronous RAM whose data word is split into equal byte lanes, each with its own enable bit. A write updates only the lanes whose enable bit is set. Every other lane keeps what it held before. The lane width is a parameter, either 8 or 9 bits, and the word is a whole number of lanes.

The read data port is one registered stage. On a pure read cycle it loads the addressed word. On a write cycle it reports each lane on its own terms:

- A lane that is not being written always shows its stored old contents.
- A lane that is being written shows either the new data or the old data. A parameter picks which for the whole block.

When neither read nor write is requested, the output holds its last value. A reset clears only the output register and does not touch the array.

Top module: `brw_ram`

## Requirements
- R1: Enable bit i governs data bits [i*LANE_W +: LANE_W], so the most significant enable bit drives the most significant lane. With two 8-bit lanes, writing 16'hABCD with enable 2'b10 over 16'hFFFF stores 16'hABFF. Enable 2'b01 stores 16'hFFCD, and enable 2'b11 stores 16'hABCD.
- R2: A write cycle (wr_en=1) stores the write-data lane into each enabled lane at the addressed location. Every disabled lane keeps its previous contents.
- R3: A write with lane_en all zero leaves the location unchanged. The output after that cycle shows the old word.
- R4: In a write cycle, each output lane whose enable is 0 shows the old stored contents of that lane, one clock after the edge.
- R5: With RDW_MODE=1, each output lane whose enable is 1 shows the new write data in a write cycle. The output is therefore the merged word.
- R6: With RDW_MODE=0, each output lane whose enable is 1 shows the old stored data in a write cycle. The output is therefore the whole old word.
- R7: A cycle with rd_en=1 and wr_en=0 loads the stored word at addr into rd_data, visible after that clock edge. When wr_en=1, the write behaviour applies whatever rd_en is.
- R8: A cycle with both rd_en=0 and wr_en=0 leaves rd_data unchanged.
- R9: While rst_n=0, rd_data is cleared to zero at the clock edge.
- R10: The lane width may be 9 as well as 8. A 9-bit-lane instance follows R1 to R8 with 9-bit lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| addr | input | ADDR_W | Word address |
| wr_data | input | LANE_W*LANES | Write data |
| lane_en | input | LANES | Per-lane write enable, bit i for lane i |
| rd_data | output | LANE_W*LANES | Registered read data |

## Verification
The storing of a partial write and the registered output fall in the same cycle. In that cycle, enabled and disabled lanes must resolve differently, and rd_en may also be asserted on top of the write. The bench provokes this by sweeping every address, every enable pattern and rd_en both low and high. It runs two instances side by side: 8-bit lanes in new-data mode, and 9-bit lanes in old-data mode. Each write's output is judged against a lane mask computed from a reference array, and a later read of the same location confirms what was actually stored.

// File: rtl/brw_pkg.sv
package brw_pkg;

  localparam int unsigned RDW_OLD = 0;
  localparam int unsigned RDW_NEW = 1;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // a write dominates a simultaneous read request
  function automatic op_e decode_op(input logic we, input logic re);
    if (we)      return OP_WRITE;
    else if (re) return OP_READ;
    else         return OP_IDLE;
  endfunction

endpackage

// File: rtl/brw_lane_merge.sv
module brw_lane_merge #(
  parameter int unsigned LANE_W   = 8,
  parameter int unsigned LANES    = 2,
  parameter int unsigned RDW_MODE = 1,
  localparam int unsigned DATA_W  = LANE_W * LANES
) (
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] new_word,
  input  logic [LANES-1:0]  lane_en,
  output logic [DATA_W-1:0] merged_word,
  output logic [DATA_W-1:0] rdw_word
);

  // lane that gets stored
  function automatic logic [LANE_W-1:0] store_lane(
    input logic en, input logic [LANE_W-1:0] o, input logic [LANE_W-1:0] n);
    return en ? n : o;
  endfunction

  // lane that the output reports during a write
  function automatic logic [LANE_W-1:0] show_lane(
    input logic en, input logic [LANE_W-1:0] o, input logic [LANE_W-1:0] n);
    if (en && (RDW_MODE == brw_pkg::RDW_NEW)) return n;
    else                                      return o;
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] old_l;
    logic [LANE_W-1:0] new_l;
    assign old_l = old_word[i*LANE_W +: LANE_W];
    assign new_l = new_word[i*LANE_W +: LANE_W];
    assign merged_word[i*LANE_W +: LANE_W] = store_lane(lane_en[i], old_l, new_l);
    assign rdw_word[i*LANE_W +: LANE_W]    = show_lane(lane_en[i], old_l, new_l);
  end

endmodule

// File: rtl/brw_store.sv
module brw_store #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] merged_word,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] new_word,
  output logic [DATA_W-1:0] rd_word
);

  logic [DATA_W-1:0] mem [DEPTH];

  assign rd_word = mem[addr];

  always_ff @(posedge clk) begin
    if (wr_evt) mem[addr] <= merged_word;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    // R2
    keep_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_evt && !lane_en[i]) |=>
        mem[$past(addr)][i*LANE_W +: LANE_W] == $past(rd_word[i*LANE_W +: LANE_W]));
    // R2
    write_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_evt && lane_en[i]) |=>
        mem[$past(addr)][i*LANE_W +: LANE_W] == $past(new_word[i*LANE_W +: LANE_W]));
  end

endmodule

// File: rtl/brw_outreg.sv
module brw_outreg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] rdw_word,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] q
);
  import brw_pkg::*;

  op_e op;
  assign op = decode_op(wr_en, rd_en);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else begin
      case (op)
        OP_WRITE: q <= rdw_word;
        OP_READ:  q <= rd_word;
        default:  q <= q;
      endcase
    end
  end

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_en) |=> $stable(q));
  // R7
  read_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> q == $past(rd_word));
  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> q == '0);

endmodule

// File: rtl/brw_ram.sv
module brw_ram #(
  parameter int unsigned LANE_W   = 8,
  parameter int unsigned LANES    = 2,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned RDW_MODE = 1,
  localparam int unsigned DATA_W  = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  lane_en,
  output logic [DATA_W-1:0] rd_data
);

  if (!(LANE_W == 8 || LANE_W == 9)) begin : g_bad_lane
    initial $fatal(1, "brw_ram: LANE_W must be 8 or 9");
  end
  if (RDW_MODE > 1) begin : g_bad_mode
    initial $fatal(1, "brw_ram: RDW_MODE must be 0 or 1");
  end

  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] merged_word;
  logic [DATA_W-1:0] rdw_word;
  logic              wr_evt;

  assign wr_evt = wr_en;

  brw_lane_merge #(
    .LANE_W(LANE_W), .LANES(LANES), .RDW_MODE(RDW_MODE)
  ) u_merge (
    .old_word(rd_word), .new_word(wr_data), .lane_en(lane_en),
    .merged_word(merged_word), .rdw_word(rdw_word)
  );

  brw_store #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANE_W(LANE_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .addr(addr),
    .merged_word(merged_word), .lane_en(lane_en), .new_word(wr_data),
    .rd_word(rd_word)
  );

  brw_outreg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .rdw_word(rdw_word), .rd_word(rd_word), .q(rd_data)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_out_chk
    // R4
    off_lane_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !lane_en[i]) |=>
        rd_data[i*LANE_W +: LANE_W] == $past(rd_word[i*LANE_W +: LANE_W]));
    if (RDW_MODE == 1) begin : g_new
      // R5
      on_lane_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lane_en[i]) |=>
          rd_data[i*LANE_W +: LANE_W] == $past(wr_data[i*LANE_W +: LANE_W]));
    end else begin : g_old
      // R6
      on_lane_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lane_en[i]) |=>
          rd_data[i*LANE_W +: LANE_W] == $past(rd_word[i*LANE_W +: LANE_W]));
    end
  end

  // R3
  zero_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lane_en == '0) |=> rd_data == $past(rd_word));

endmodule

// File: tb/brw_ram_tb.sv
module brw_ram_tb;
  localparam int CLK_P = 10;
  localparam int AW = 3;

  logic clk = 0;
  logic rst_n;
  logic wr_en, rd_en;
  logic [AW-1:0] addr;
  logic [15:0] wd8;
  logic [17:0] wd9;
  logic [1:0] be;
  logic [15:0] q8;
  logic [17:0] q9;

  int checks = 0;
  int errors = 0;

  logic [15:0] ref8 [8];
  logic [17:0] ref9 [8];

  always #(CLK_P/2) clk = ~clk;

  brw_ram #(.LANE_W(8), .LANES(2), .ADDR_W(AW), .RDW_MODE(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wd8), .lane_en(be), .rd_data(q8));

  brw_ram #(.LANE_W(9), .LANES(2), .ADDR_W(AW), .RDW_MODE(0)) u_dut9 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wd9), .lane_en(be), .rd_data(q9));

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mask8(input logic [1:0] b);
    return {{8{b[1]}}, {8{b[0]}}};
  endfunction
  function automatic logic [17:0] mask9(input logic [1:0] b);
    return {{9{b[1]}}, {9{b[0]}}};
  endfunction

  // one access: drive after a falling edge, check after the next falling edge
  task automatic access(input logic we, input logic re, input logic [AW-1:0] a,
                        input logic [15:0] d8, input logic [17:0] d9,
                        input logic [1:0] b, input string tag);
    logic [15:0] e8;
    logic [17:0] e9;
    logic [15:0] m8;
    logic [17:0] m9;
    m8 = mask8(b);
    m9 = mask9(b);
    e8 = q8;
    e9 = q9;
    if (we) begin
      e8 = (d8 & m8) | (ref8[a] & ~m8);  // new-data mode: merged word
      e9 = ref9[a];                      // old-data mode: old word
      ref8[a] = (d8 & m8) | (ref8[a] & ~m8);
      ref9[a] = (d9 & m9) | (ref9[a] & ~m9);
    end else if (re) begin
      e8 = ref8[a];
      e9 = ref9[a];
    end
    wr_en = we; rd_en = re; addr = a; wd8 = d8; wd9 = d9; be = b;
    @(negedge clk);
    chk({tag, " lw8"}, {2'b0, q8}, {2'b0, e8});
    chk({tag, " lw9 R10"}, q9, e9);
  endtask

  initial begin
    #(CLK_P * 40000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; wr_en = 0; rd_en = 0; addr = '0; wd8 = '0; wd9 = '0; be = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset lw8", {2'b0, q8}, 18'h0);
    chk("R9 reset lw9", q9, 18'h0);
    rst_n = 1;

    for (int a = 0; a < 8; a++) begin
      ref8[a] = 'x; ref9[a] = 'x;
    end
    // fill all words with all-ones
    for (int a = 0; a < 8; a++)
      access(1'b1, 1'b0, AW'(a), 16'hFFFF, 18'h3FFFF, 2'b11, "R2 fill");

    // directed lane-order cases
    access(1'b1, 1'b0, 3'd0, 16'hABCD, 18'h15A5A, 2'b10, "R1 R5 R6 be10");
    chk("R1 be10 out", {2'b0, q8}, 18'h0ABFF);
    access(1'b1, 1'b0, 3'd1, 16'hABCD, 18'h15A5A, 2'b01, "R1 R5 R6 be01");
    chk("R1 be01 out", {2'b0, q8}, 18'h0FFCD);
    access(1'b1, 1'b0, 3'd2, 16'hABCD, 18'h15A5A, 2'b11, "R1 R5 R6 be11");
    access(1'b0, 1'b1, 3'd0, 16'h0, 18'h0, 2'b00, "R1 R7 read a0");
    chk("R1 stored a0", {2'b0, q8}, 18'h0ABFF);
    access(1'b0, 1'b1, 3'd1, 16'h0, 18'h0, 2'b00, "R1 R7 read a1");
    chk("R1 stored a1", {2'b0, q8}, 18'h0FFCD);
    access(1'b0, 1'b1, 3'd2, 16'h0, 18'h0, 2'b00, "R1 R7 read a2");
    chk("R1 stored a2", {2'b0, q8}, 18'h0ABCD);
    access(1'b0, 1'b0, 3'd5, 16'h1234, 18'h1234, 2'b11, "R8 idle hold");

    // sweep: every address, enable pattern and read request level
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 4; b++) begin
        for (int k = 0; k < 3; k++) begin
          logic [17:0] d;
          d = 18'((a * 9371 + b * 40503 + k * 77773 + 12345) % 262144);
          access(1'b1, k == 1, AW'(a), d[15:0], d, 2'(b),
                 (b == 0) ? "R3 zero-enable write" : "R2 R4 R5 R6 write");
          access(1'b0, 1'b1, AW'(a), 16'h0, 18'h0, 2'b00, "R2 R3 R7 readback");
          access(1'b0, 1'b0, AW'((a + 3) % 8), ~d[15:0], ~d, 2'(3 - b), "R8 idle");
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule